// File: doc/BRIEF.md
# Buffered Streaming Serial Master

This block is a serial master that moves 8-bit frames out on a data line and in from a return line, one after another, through a single data register. Software writes the next outgoing word into the data register and reads the most recently received word from it. A hold stage between that register and the shift register lets frames run back to back: if a word is waiting when one frame finishes, the next frame starts on the very next bit period.

The channel runs only after a start trigger. A stop trigger halts it at once, even mid-frame. Two status flags report progress: `busy_o` is high while a frame is shifting, and `buf_full_o` is high while a written word has not yet been taken. The interrupt is a single-cycle pulse. Its trigger depends on the interrupt-mode input:

- In transfer-end mode it fires when the line goes idle.
- In buffer-empty mode it fires each time a waiting word moves into the shift register.

The mode may be switched while the channel runs. A streaming driver works in buffer-empty mode and switches to transfer-end mode once the last word is written. That way the final interrupt marks completion.

The serial clock idles high. Each bit is a low half followed by a high half. Outgoing data changes at each falling edge and incoming data is sampled at each rising edge.

Top module: `spi_stream_master`

## Requirements
- R1: After reset: `enabled_o`, `busy_o`, `buf_full_o` and `irq_o` are 0, `sclk_o` and `mosi_o` are 1, and `rd_data_o` is 0.
- R2: A `start_i` pulse sets `enabled_o` on the next edge. A `stop_i` pulse clears it, and `stop_i` wins when both are asserted together.
- R3: A `wr_en_i` cycle sets `buf_full_o` and stores `wr_data_i`. A second write before the word is taken replaces it, so only the last word is ever sent.
- R4: A frame starts on the edge after `enabled_o` and `buf_full_o` are both high while idle. At that edge the word moves to the shift register, `buf_full_o` clears and `busy_o` rises. With `irq_mode_i`=1 (buffer-empty), `irq_o` is high for exactly that one cycle.
- R5: While busy, each of the 8 bits lasts 2*H system cycles: `sclk_o` is low for H cycles, then high for H cycles. H is `half_div_i`, with 0 treated as 1. `mosi_o` presents bit 7 first and changes only when `sclk_o` falls.
- R6: `miso_i` is captured on the system edge that raises `sclk_o`, with the first capture landing in bit 7. The assembled word appears on `rd_data_o` on the edge that ends the frame.
- R7: If `buf_full_o` is high when a frame ends, the next frame starts on that same edge. `busy_o` stays high with no idle cycle and `sclk_o` falls again immediately.
- R8: If no word waits when a frame ends, `busy_o` drops and `sclk_o`/`mosi_o` return to 1. With `irq_mode_i`=0 (transfer-end), `irq_o` pulses for that one cycle. Frames that chain into a following frame raise no transfer-end pulse.
- R9: `irq_mode_i` is sampled at each event, so it may be changed while frames run.
- R10: `rd_data_o` changes only on the edge that ends a frame. Reads and writes during a frame leave it and the frame in progress unchanged.
- R11: `stop_i` aborts any frame on the next edge. `busy_o`, `buf_full_o` and `enabled_o` go to 0, `sclk_o`/`mosi_o` go to 1, no interrupt is raised and `rd_data_o` is kept.
- R12: While `enabled_o` is 0, a written word waits in the buffer and no frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start trigger pulse |
| stop_i | input | 1 | Stop trigger pulse |
| irq_mode_i | input | 1 | 0 = transfer-end interrupt, 1 = buffer-empty interrupt |
| half_div_i | input | DIV_W | System cycles per serial clock half (0 acts as 1) |
| wr_en_i | input | 1 | Data register write strobe |
| wr_data_i | input | DATA_W | Transmit word |
| rd_data_o | output | DATA_W | Last received word |
| enabled_o | output | 1 | Channel running status |
| busy_o | output | 1 | Frame shifting |
| buf_full_o | output | 1 | Unsent word buffered |
| sclk_o | output | 1 | Serial clock, idle high |
| mosi_o | output | 1 | Serial data out, idle high |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Single-cycle interrupt pulse |

## Verification
The bench goes after chaining at the frame boundary. A design that inserts an idle cycle there stretches a two-word burst beyond 32*H cycles. A design that fires a transfer-end pulse between chained frames gives the wrong interrupt count when the mode is switched mid-stream. A write that lands on the same edge a buffered word is taken must both send the old word and keep the new one; losing either one shows up as a wrong MOSI bit or a dropped `buf_full_o`. It also covers aborting a frame mid-shift, which must idle the pins without touching `rd_data_o`, and the H=0 divider case, which must behave exactly like H=1.

// File: rtl/spi_stream_pkg.sv
package spi_stream_pkg;
  typedef enum logic {
    IRQ_XFER_END  = 1'b0,
    IRQ_BUF_EMPTY = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/spi_sclk_div.sv
module spi_sclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] reload;

  // a zero divider acts as one cycle per half
  always_comb reload = (half_div_i == '0) ? '0 : half_div_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= reload;
    end else if (busy_i) begin
      if (cnt_q == '0) cnt_q <= reload;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick_o = busy_i && (cnt_q == '0);
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              frame_end_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_word_o
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              busy_q;
  logic              hi_q;
  logic [CNT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] rx_q;

  assign frame_end_o = busy_q && tick_i && hi_q && (bit_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      hi_q   <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else if (stop_i) begin
      busy_q <= 1'b0;
      hi_q   <= 1'b0;
      bit_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      hi_q   <= 1'b0;
      bit_q  <= '0;
      sh_q   <= tx_word_i;
    end else if (busy_q && tick_i) begin
      if (!hi_q) begin
        // rising serial edge: capture
        hi_q <= 1'b1;
        rx_q <= {rx_q[DATA_W-2:0], miso_i};
      end else if (frame_end_o) begin
        busy_q <= 1'b0;
        hi_q   <= 1'b0;
      end else begin
        // falling serial edge: next bit out
        hi_q  <= 1'b0;
        bit_q <= bit_q + 1'b1;
        sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign busy_o    = busy_q;
  assign sclk_o    = busy_q ? hi_q : 1'b1;
  assign mosi_o    = busy_q ? sh_q[DATA_W-1] : 1'b1;
  assign rx_word_o = rx_q;

  p_stop_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!busy_o && sclk_o && mosi_o));

  p_load_starts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !stop_i) |=> (busy_o && !sclk_o));

  p_end_idles_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_o && !load_i && !stop_i) |=> (!busy_o && sclk_o && mosi_o));
endmodule

// File: rtl/spi_data_buf.sv
module spi_data_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  input  logic              frame_end_i,
  input  logic [DATA_W-1:0] rx_word_i,
  output logic              enabled_o,
  output logic              full_o,
  output logic [DATA_W-1:0] tx_word_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              en_q;
  logic              full_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      full_q <= 1'b0;
      tx_q   <= '0;
      rd_q   <= '0;
    end else if (stop_i) begin
      en_q   <= 1'b0;
      full_q <= 1'b0;
    end else begin
      if (start_i) en_q <= 1'b1;
      // a write on the take edge refills the buffer
      if (wr_en_i) begin
        full_q <= 1'b1;
        tx_q   <= wr_data_i;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
      if (frame_end_i) rd_q <= rx_word_i;
    end
  end

  assign enabled_o = en_q;
  assign full_o    = full_q;
  assign tx_word_o = tx_q;
  assign rd_data_o = rd_q;

  p_stop_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!enabled_o && !full_o));

  p_start_enables_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> enabled_o);

  p_write_fills_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !stop_i) |=> (full_o && tx_word_o == $past(wr_data_i)));

  p_rd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(rd_data_o));
endmodule

// File: rtl/spi_stream_master.sv
module spi_stream_master
  import spi_stream_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              irq_mode_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              enabled_o,
  output logic              busy_o,
  output logic              buf_full_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              irq_o
);
  logic              tick;
  logic              busy;
  logic              frame_end;
  logic              take;
  logic              enabled;
  logic              full;
  logic [DATA_W-1:0] tx_word;
  logic [DATA_W-1:0] rx_word;
  logic              irq_q;
  irq_mode_e         mode;

  assign mode = irq_mode_e'(irq_mode_i);
  // chain on the closing edge of a frame, or start from idle
  assign take = full && enabled && (!busy || frame_end) && !stop_i;

  spi_sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy),
    .load_i     (take),
    .half_div_i (half_div_i),
    .tick_o     (tick)
  );

  spi_frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stop_i      (stop_i),
    .load_i      (take),
    .tx_word_i   (tx_word),
    .tick_i      (tick),
    .miso_i      (miso_i),
    .busy_o      (busy),
    .frame_end_o (frame_end),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .rx_word_o   (rx_word)
  );

  spi_data_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .take_i      (take),
    .frame_end_i (frame_end && !stop_i),
    .rx_word_i   (rx_word),
    .enabled_o   (enabled),
    .full_o      (full),
    .tx_word_o   (tx_word),
    .rd_data_o   (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else irq_q <= !stop_i &&
                  ((take && mode == IRQ_BUF_EMPTY) ||
                   (frame_end && !take && mode == IRQ_XFER_END));
  end

  assign enabled_o  = enabled;
  assign busy_o     = busy;
  assign buf_full_o = full;
  assign irq_o      = irq_q;

  p_irq_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_no_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end && full && !stop_i) |=> busy_o);

  p_start_gated_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(enabled_o));

  p_end_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end && !full && !stop_i && mode == IRQ_XFER_END) |=> (irq_o && !busy_o));
endmodule

// File: tb/tb_spi_stream_master.sv
`timescale 1ns/1ps
module tb_spi_stream_master;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, stop_i = 1'b0, irq_mode_i = 1'b0;
  logic [7:0] half_div_i = 8'd2;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       enabled_o, busy_o, buf_full_o, sclk_o, mosi_o, irq_o;
  logic       miso_i = 1'b0;

  int vectors = 0, fails = 0, wd = 0, irq_cnt = 0;

  always #2 clk = ~clk;

  spi_stream_master dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .irq_mode_i(irq_mode_i), .half_div_i(half_div_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .enabled_o(enabled_o),
    .busy_o(busy_o), .buf_full_o(buf_full_o), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .irq_o(irq_o)
  );

  // behavioural reference: frame position counted in system cycles
  bit m_en, m_busy, m_full, m_irq, m_end, m_take;
  int m_txbuf, m_word, m_cyc, m_rx, m_rd, m_h, h_now;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = 0; m_busy = 0; m_full = 0; m_irq = 0;
      m_txbuf = 0; m_word = 0; m_cyc = 0; m_rx = 0; m_rd = 0; m_h = 1;
    end else begin
      h_now = (half_div_i == 0) ? 1 : int'(half_div_i);
      m_irq = 0;
      m_end = m_busy && (m_cyc == 16 * m_h - 1);
      if (m_busy && (m_cyc % (2 * m_h)) == m_h - 1)
        m_rx = ((m_rx << 1) | int'(miso_i)) & 8'hFF;
      m_take = m_full && m_en && (!m_busy || m_end) && !stop_i;
      if (stop_i) begin
        m_en = 0; m_busy = 0; m_full = 0;
      end else begin
        if (start_i) m_en = 1;
        if (m_end) begin
          m_rd = m_rx;
          if (!m_take) begin
            m_busy = 0;
            if (!irq_mode_i) m_irq = 1;
          end
        end
        if (m_take) begin
          m_word = m_txbuf; m_busy = 1; m_cyc = 0; m_h = h_now; m_full = 0;
          if (irq_mode_i) m_irq = 1;
        end else if (m_busy) begin
          m_cyc++;
        end
        if (wr_en_i) begin
          m_full = 1; m_txbuf = int'(wr_data_i);
        end
      end
    end
  end

  function automatic bit ref_sclk();
    return m_busy ? bit'((m_cyc / m_h) % 2) : 1'b1;
  endfunction
  function automatic bit ref_mosi();
    return m_busy ? bit'((m_word >> (7 - m_cyc / (2 * m_h))) & 1) : 1'b1;
  endfunction

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    bit bad;
    bad = 0;
    vectors++;
    if (enabled_o !== m_en) begin bad = 1;
      $display("FAIL R2 enabled_o act=%0b exp=%0b t=%0t", enabled_o, m_en, $time); end
    if (buf_full_o !== m_full) begin bad = 1;
      $display("FAIL R3 buf_full_o act=%0b exp=%0b t=%0t", buf_full_o, m_full, $time); end
    if (busy_o !== m_busy) begin bad = 1;
      $display("FAIL R7 busy_o act=%0b exp=%0b t=%0t", busy_o, m_busy, $time); end
    if (sclk_o !== ref_sclk()) begin bad = 1;
      $display("FAIL R5 sclk_o act=%0b exp=%0b t=%0t", sclk_o, ref_sclk(), $time); end
    if (mosi_o !== ref_mosi()) begin bad = 1;
      $display("FAIL R5 mosi_o act=%0b exp=%0b t=%0t", mosi_o, ref_mosi(), $time); end
    if (irq_o !== m_irq) begin bad = 1;
      $display("FAIL R4|R8 irq_o act=%0b exp=%0b t=%0t", irq_o, m_irq, $time); end
    if (int'(rd_data_o) !== m_rd) begin bad = 1;
      $display("FAIL R6 rd_data_o act=%0h exp=%0h t=%0t", rd_data_o, m_rd, $time); end
    if (bad) fails++;
    if (irq_o) irq_cnt++;
    miso_i = 1'($urandom);
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp<%0d", wd, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1; @(negedge clk) start_i = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk) stop_i = 1; @(negedge clk) stop_i = 0;
  endtask
  task automatic write(input logic [7:0] d);
    @(negedge clk) begin wr_en_i = 1; wr_data_i = d; end
    @(negedge clk) wr_en_i = 0;
  endtask
  task automatic wait_idle();
    while (busy_o || buf_full_o) @(negedge clk);
  endtask
  task automatic busy_len(output int n);
    while (!busy_o) @(negedge clk);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!enabled_o && !busy_o && !buf_full_o && !irq_o, "R1 flags", {enabled_o, busy_o, buf_full_o, irq_o}, 0);
    chk(sclk_o && mosi_o, "R1 pins", {sclk_o, mosi_o}, 3);
    chk(rd_data_o == 0, "R1 rd_data", rd_data_o, 0);
    rst_ni = 1;

    // R2: start enables
    half_div_i = 8'd2; irq_mode_i = 1;
    pulse_start();
    chk(enabled_o, "R2 enable", enabled_o, 1);

    // R4: buffer-empty irq coincides with frame start
    irq_cnt = 0;
    @(negedge clk) begin wr_en_i = 1; wr_data_i = 8'hA5; end
    @(negedge clk) wr_en_i = 0;
    while (!busy_o) @(negedge clk);
    chk(irq_o && !buf_full_o, "R4 take irq", {irq_o, buf_full_o}, 2);
    // R9: stream three more, switch to transfer-end before last word
    while (buf_full_o) @(negedge clk);
    write(8'h3C);
    while (buf_full_o) @(negedge clk);
    write(8'hF0);
    while (buf_full_o) @(negedge clk);
    irq_mode_i = 0;
    write(8'h81);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(irq_cnt == 4, "R9 irq count", irq_cnt, 4);

    // R8: transfer-end irq when line idles
    write(8'h5A);
    while (!busy_o) @(negedge clk);
    while (busy_o) @(negedge clk);
    chk(irq_o && sclk_o && mosi_o, "R8 end irq", {irq_o, sclk_o, mosi_o}, 7);

    // R12 + R3: no start while disabled, overwrite keeps last word
    pulse_stop();
    write(8'h9C);
    write(8'h3C);
    repeat (10) @(negedge clk);
    chk(!busy_o && buf_full_o, "R12 held", {busy_o, buf_full_o}, 1);
    pulse_start();
    while (!busy_o) @(negedge clk);
    chk(mosi_o == 0, "R3 overwrite msb", mosi_o, 0);
    wait_idle();

    // R5: divider zero behaves as one
    half_div_i = 8'd0;
    write(8'hC3);
    busy_len(n);
    chk(n == 16, "R5 h0 length", n, 16);

    // R7: chained frames without a gap, including write on take edge
    half_div_i = 8'd3;
    @(negedge clk) begin wr_en_i = 1; wr_data_i = 8'h96; end
    @(negedge clk) wr_data_i = 8'h69;
    @(negedge clk) wr_en_i = 0;
    busy_len(n);
    chk(n == 96, "R7 chain length", n, 96);

    // R10: rd_data holds through a frame
    write(8'h0F);
    while (!busy_o) @(negedge clk);
    n = int'(rd_data_o);
    repeat (20) @(negedge clk);
    chk(int'(rd_data_o) == n && busy_o, "R10 hold", rd_data_o, n);
    wait_idle();

    // R11: abort mid-frame with a word pending
    half_div_i = 8'd4;
    write(8'hE7);
    write(8'h18);
    repeat (9) @(negedge clk);
    n = int'(rd_data_o);
    @(negedge clk) stop_i = 1;
    @(negedge clk) stop_i = 0;
    chk(!busy_o && !buf_full_o && !enabled_o && sclk_o && mosi_o, "R11 abort",
        {busy_o, buf_full_o, enabled_o, sclk_o, mosi_o}, 3);
    chk(int'(rd_data_o) == n && !irq_o, "R11 rd kept", rd_data_o, n);

    // R6: received data after restart
    half_div_i = 8'd1;
    pulse_start();
    write(8'h42);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(int'(rd_data_o) == m_rd, "R6 rx word", rd_data_o, m_rd);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule